// File: doc/BRIEF.md
# I2C Register-Read Target

This block is an I2C target that gives a bus controller read access to sixteen 9-bit words. The words arrive on a parallel side port, so the surrounding logic keeps them current and the block only serialises them. SCL and SDA are oversampled on the system clock. The block recognises start, repeated-start and stop conditions. It drives SDA only as an open-drain pull-down, through an output-enable.

A controller selects a word in one of two ways. In the random form it sends a write-addressed control byte, then a command byte that holds a 4-bit word address and a read opcode, then a repeated start and a read-addressed control byte. In the current-address form it sends only a read-addressed control byte, and the block answers from the address it last accepted. Either way the word comes back as two bytes: the top data bit alone in the first byte, the low eight bits in the second. The address pointer survives Stop and repeated start. Only reset clears it.

Top module: `i2c_regread_target`

## Requirements
- R1: The 7-bit target address is binary 0101 in its upper four bits and `strap_addr` in its lower three, followed by the R/W bit (1 = read). On a match the block pulls SDA low in the acknowledge slot. On a mismatch it leaves SDA released there and for every later bit until the next start condition.
- R2: The command byte is taken MSB first. Bits 7:4 are the word address and bits 3:2 are the opcode. Opcode 11 is acknowledged and loads the address into the pointer.
- R3: A command byte whose opcode is not 11 is not acknowledged and leaves the pointer unchanged.
- R4: In a random read (write control byte, command, repeated start, read control byte), the returned word is the one at the address just given.
- R5: A current-address read returns the word at the retained pointer. The pointer is kept across Stop and repeated start, and it changes only when a read command is accepted.
- R6: After reset the pointer is 0 and SDA is released.
- R7: Read data is sent MSB first. The first byte is seven zeros followed by data bit 8. The second byte is data bits 7 down to 0.
- R8: If the controller does not acknowledge the first data byte, the block releases SDA and drives nothing until a start or stop condition.
- R9: After the second data byte the block releases SDA and drives nothing more until a start condition, whatever the controller answers.
- R10: The output-enable turns on only while SCL is low.
- R11: A stop condition releases SDA and returns the block to idle. A start condition at any point restarts reception of a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high (power-on and brown-out) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_addr | input | 3 | Strap-selected low bits of the target address |
| reg_flat | input | NREG*DATA_W | Word k in bits [k*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its default values: sixteen 9-bit words and a two-stage synchronizer. The full address range and data bit 8 are therefore exercised on every read form. The bus model spaces its SCL edges eight system clocks apart, which leaves room for the synchronizer delay. This lets the bench test the acknowledge slots, the early release after a NACK, and stops or starts placed in the middle of a byte. Random traffic mixes random reads, current-address reads across Stop and repeated start, rejected opcodes and foreign addresses, all against a model of the pointer and of the word array.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    NX_TX,
    NX_CMD,
    NX_WAIT
  } after_ack_t;

  localparam logic [1:0] CMD_READ = 2'b11;

  // Control byte: fixed nibble, strap bits, then R/W in bit 0.
  function automatic logic ctrl_match(input logic [7:0] b,
                                      input logic [3:0] fixed,
                                      input logic [2:0] strap);
    return (b[7:4] == fixed) && (b[3:1] == strap);
  endfunction

  function automatic logic [7:0] hi_byte(input logic [15:0] w);
    return w[15:8];
  endfunction

  function automatic logic [7:0] lo_byte(input logic [15:0] w);
    return w[7:0];
  endfunction

endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rr_fsm.sv
module i2c_rr_fsm
  import i2c_rr_pkg::*;
#(
  parameter int          PTR_W      = 4,
  parameter logic [3:0]  FIXED_ADDR = 4'b0101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [2:0]       strap,
  input  logic [15:0]      rd_word,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr
);

  localparam int CMD_LSB = 8 - PTR_W - 2;

  phase_t     phase;
  after_ack_t nxt;
  logic [3:0]  cnt;
  logic [7:0]  shreg;
  logic [7:0]  tx_sh;
  logic [15:0] tx_word;
  logic        hi_seen;
  logic        rx_cmd;
  logic        tx_second;
  logic        mack_ok;

  // Named events for the assertions below.
  logic byte_full, ctrl_hit, ctrl_miss, cmd_accept, cmd_reject;
  logic ack_done, mack_done, tx_bit_done;

  assign byte_full   = (phase == ST_RX) && (cnt == 4'd8) && scl_fall;
  assign ctrl_hit    = byte_full && !rx_cmd && ctrl_match(shreg, FIXED_ADDR, strap);
  assign ctrl_miss   = byte_full && !rx_cmd && !ctrl_match(shreg, FIXED_ADDR, strap);
  assign cmd_accept  = byte_full && rx_cmd && (shreg[CMD_LSB+1:CMD_LSB] == CMD_READ);
  assign cmd_reject  = byte_full && rx_cmd && (shreg[CMD_LSB+1:CMD_LSB] != CMD_READ);
  assign ack_done    = (phase == ST_ACK) && hi_seen && scl_fall;
  assign mack_done   = (phase == ST_MACK) && hi_seen && scl_fall;
  assign tx_bit_done = (phase == ST_TX) && scl_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_IDLE;
      nxt       <= NX_WAIT;
      cnt       <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      tx_word   <= '0;
      hi_seen   <= 1'b0;
      rx_cmd    <= 1'b0;
      tx_second <= 1'b0;
      mack_ok   <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
    end else if (start_det) begin
      phase   <= ST_RX;
      rx_cmd  <= 1'b0;
      cnt     <= '0;
      hi_seen <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      phase  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (phase)
        ST_RX: begin
          if (byte_full) begin
            hi_seen <= 1'b0;
            if (ctrl_hit) begin
              phase  <= ST_ACK;
              sda_oe <= 1'b1;
              nxt    <= shreg[0] ? NX_TX : NX_CMD;
            end else if (cmd_accept) begin
              ptr    <= shreg[7:8-PTR_W];
              phase  <= ST_ACK;
              sda_oe <= 1'b1;
              nxt    <= NX_WAIT;
            end else begin
              phase <= ST_WAIT;
            end
          end else if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            hi_seen <= 1'b1;
          end else if (ack_done) begin
            hi_seen <= 1'b0;
            sda_oe  <= 1'b0;
            case (nxt)
              NX_TX: begin
                tx_word   <= rd_word;
                tx_sh     <= hi_byte(rd_word);
                sda_oe    <= ~hi_byte(rd_word)[7];
                cnt       <= '0;
                tx_second <= 1'b0;
                phase     <= ST_TX;
              end
              NX_CMD: begin
                rx_cmd <= 1'b1;
                cnt    <= '0;
                phase  <= ST_RX;
              end
              default: phase <= ST_WAIT;
            endcase
          end
        end
        ST_TX: begin
          if (tx_bit_done) begin
            if (cnt == 4'd7) begin
              sda_oe  <= 1'b0;
              hi_seen <= 1'b0;
              phase   <= ST_MACK;
            end else begin
              cnt    <= cnt + 4'd1;
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            hi_seen <= 1'b1;
            mack_ok <= ~sda_s;
          end else if (mack_done) begin
            hi_seen <= 1'b0;
            if (mack_ok && !tx_second) begin
              tx_sh     <= lo_byte(tx_word);
              sda_oe    <= ~lo_byte(tx_word)[7];
              cnt       <= '0;
              tx_second <= 1'b1;
              phase     <= ST_TX;
            end else begin
              phase <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s)); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R11
  AST_PTR_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(cmd_accept)); // R5
  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ctrl_miss |=> !sda_oe); // R1
  AST_REJECT_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    cmd_reject |=> (!sda_oe && $stable(ptr))); // R3
  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (tx_bit_done && cnt == 4'd7) |=> !sda_oe); // R8

endmodule

// File: rtl/i2c_regread_target.sv
module i2c_regread_target #(
  parameter int         DATA_W      = 9,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] FIXED_ADDR  = 4'b0101,
  localparam int        PTR_W       = 4,
  localparam int        NREG        = 1 << PTR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [2:0]             strap_addr,
  input  logic [NREG*DATA_W-1:0] reg_flat
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] sel_word;
  logic [15:0]       rd_word;

  i2c_rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign sel_word = reg_flat[ptr*DATA_W +: DATA_W];
  assign rd_word  = {{(16-DATA_W){1'b0}}, sel_word};

  i2c_rr_fsm #(.PTR_W(PTR_W), .FIXED_ADDR(FIXED_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_addr),
    .rd_word   (rd_word),
    .sda_oe    (sda_oe),
    .ptr       (ptr)
  );

endmodule

// File: tb/tb_i2c_regread_target.sv
`timescale 1ns/1ps
module tb_i2c_regread_target;

  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic bus_sda;
  logic [8:0] mem [16];
  logic [143:0] reg_flat;
  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  logic [3:0] exp_ptr;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign bus_sda = !(m_sda_low || sda_oe);

  always_comb begin
    for (int i = 0; i < 16; i++) reg_flat[i*9 +: 9] = mem[i];
  end

  i2c_regread_target dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (bus_sda),
    .sda_oe     (sda_oe),
    .strap_addr (STRAP),
    .reg_flat   (reg_flat)
  );

  function automatic logic [7:0] ctrl_byte(input logic rw);
    return {4'b0101, STRAP, rw};
  endfunction
  function automatic logic [7:0] exp_hi(input logic [8:0] w);
    return {7'b0, w[8]};
  endfunction
  function automatic logic [7:0] exp_lo(input logic [8:0] w);
    return w[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c;
    m_sda_low = 1'b0; wq;
    m_scl = 1'b1; wq;
    m_sda_low = 1'b1; wq;
    m_scl = 1'b0; wq;
  endtask

  task automatic stop_c;
    m_sda_low = 1'b1; wq;
    m_scl = 1'b1; wq;
    m_sda_low = 1'b0; wq;
  endtask

  task automatic wbit(input logic b);
    m_sda_low = !b; wq;
    m_scl = 1'b1; wq; wq;
    m_scl = 1'b0; wq;
  endtask

  task automatic rbit(output logic b);
    m_sda_low = 1'b0; wq;
    m_scl = 1'b1; wq;
    b = bus_sda; wq;
    m_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(!ack);
  endtask

  // Monitor: output-enable may only turn on while SCL is low (R10).
  always @(negedge clk) begin
    if (!rst && sda_oe && !prev_oe && m_scl) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic cur_read(input logic do_stop);
    logic a; logic [7:0] h, l;
    start_c;
    send_byte(ctrl_byte(1'b1), a);
    chk("R1 read control ack", a, 1);
    recv_byte(h, 1'b1);
    chk("R5 R7 current read hi", h, exp_hi(mem[exp_ptr]));
    recv_byte(l, 1'b0);
    chk("R5 R7 current read lo", l, exp_lo(mem[exp_ptr]));
    if (do_stop) stop_c;
  endtask

  task automatic rand_read(input logic [3:0] addr, input int mode);
    logic a; logic [7:0] h, l, x;
    start_c;
    send_byte(ctrl_byte(1'b0), a);
    chk("R1 write control ack", a, 1);
    send_byte({addr, 2'b11, 2'b00}, a);
    chk("R2 read command ack", a, 1);
    exp_ptr = addr;
    start_c;
    send_byte(ctrl_byte(1'b1), a);
    chk("R4 read control ack after Sr", a, 1);
    if (mode == 1) begin
      recv_byte(h, 1'b0);
      chk("R4 R7 hi byte", h, exp_hi(mem[addr]));
      recv_byte(x, 1'b0);
      chk("R8 released after NACK", x, 8'hFF);
    end else begin
      recv_byte(h, 1'b1);
      chk("R4 R7 hi byte", h, exp_hi(mem[addr]));
      recv_byte(l, mode == 2);
      chk("R4 R7 lo byte", l, exp_lo(mem[addr]));
      if (mode == 2) begin
        recv_byte(x, 1'b0);
        chk("R9 released after second byte", x, 8'hFF);
      end
    end
    stop_c;
  endtask

  task automatic bad_cmd(input logic [3:0] addr, input logic [1:0] code);
    logic a;
    start_c;
    send_byte(ctrl_byte(1'b0), a);
    chk("R1 write control ack", a, 1);
    send_byte({addr, code, 2'b00}, a);
    chk("R3 non-read opcode NACK", a, 0);
    stop_c;
    cur_read(1'b1);
  endtask

  task automatic foreign_addr(input logic [7:0] cb);
    logic a; logic [7:0] x;
    start_c;
    send_byte(cb, a);
    chk("R1 foreign address NACK", a, 0);
    recv_byte(x, 1'b1);
    chk("R1 ignored until start", x, 8'hFF);
    stop_c;
  endtask

  initial begin
    logic [7:0] cb;
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) mem[i] = 9'($urandom);
    exp_ptr = 4'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 SDA released after reset", sda_oe, 0);
    cur_read(1'b1);                        // R6 pointer starts at 0

    // Directed corners
    mem[3] = 9'h100; mem[12] = 9'h0FF;
    rand_read(4'd3, 0);
    rand_read(4'd15, 0);
    rand_read(4'd12, 1);                   // R8
    rand_read(4'd0, 2);                    // R9
    cur_read(1'b0);                        // R5 across Stop
    cur_read(1'b1);                        // R5 across repeated start
    bad_cmd(4'd9, 2'b01);                  // R3
    bad_cmd(4'd9, 2'b00);
    foreign_addr({4'b0101, STRAP ^ 3'b001, 1'b1});
    foreign_addr({4'b0111, STRAP, 1'b0});
    // R11: stop part-way through a control byte, then a clean read
    start_c; wbit(1'b0); wbit(1'b1); wbit(1'b0); stop_c;
    chk("R11 released after stop", sda_oe, 0);
    cur_read(1'b1);
    // R11: start part-way through a byte restarts control reception
    start_c; wbit(1'b1); wbit(1'b1); wbit(1'b0);
    cur_read(1'b1);

    // Constrained random traffic
    for (int n = 0; n < 30; n++) begin
      int kind;
      mem[$urandom_range(15)] = 9'($urandom);
      kind = $urandom_range(9);
      if (kind < 4) rand_read(4'($urandom), $urandom_range(2));
      else if (kind < 7) cur_read(1'($urandom));
      else if (kind < 8) bad_cmd(4'($urandom), 2'($urandom_range(2)));
      else begin
        cb = 8'($urandom);
        if (cb[7:1] == {4'b0101, STRAP}) cb[7] = 1'b1;
        foreign_addr(cb);
      end
    end
    stop_c;
    chk("R10 drive turns on only with SCL low", r10_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule